// File: doc/BRIEF.md
# Operand Dependency Interlock

This block sits at the issue point of a single-issue, in-order integer pipeline. Each cycle it decides whether the instruction presented may go. It holds one scoreboard slot per general register and one for the hi/lo accumulator pair. Each slot records the class of the youngest instruction that will write that register and the cycle in which that instruction issued. The stall output is a purely combinational function of the scoreboard, a free-running cycle counter and the presented instruction.

An incoming instruction gives its producer class, an optional general destination, an optional hi/lo destination, and up to `NUM_SRC` sources. Each source is tagged with how it is consumed: plain operand, address base, store data, or accumulator read. The distance required between producer and consumer depends on both the producer class and the consumer's use. Address-base use needs one cycle more than plain use, and store data uses the plain figure. A static mode input picks between the half-rate and full-rate floating-point latencies for the two classes that come from the float side.

When the instruction issues, its destinations overwrite their slots. A synchronous flush empties the scoreboard.

Top module: `ilk_interlock`

## Requirements
- R1: After reset, and in the cycle after a flush, no slot is pending: a presented instruction does not stall whatever it reads. An instruction presented in a flush cycle is not recorded.
- R2: Plain-use distance, counted in cycles from the producer's issue edge to the consumer's issue edge, is set by the producer class code (`issue_cls`):
  - 0 (arithmetic, shift, compare, constant): 1
  - 1 (load): 2
  - 2 (three-operand multiply into a general register): 5
  - 3 (move from hi/lo): 5
  - 4 (move to hi/lo): 1
  - 5 (pipelined multiply or multiply-accumulate into hi/lo): 1
  - 6 (float-to-integer conversion): 10 or 5
  - 7 (coprocessor register transfer): 4 or 2

  A slot stops blocking once its distance has been met, however long ago it issued.
- R3: A source with use code 1 (address base of a load, store or prefetch) needs the plain distance plus one. This gives 2 after arithmetic, 3 after a load, 6 after a class 2 or 3 producer, 11 or 6 after a conversion, and 5 or 3 after a transfer.
- R4: A source with use code 2 (store data) needs exactly the plain distance, with no extra cycle.
- R5: A source with use code 3 reads the hi/lo slot and ignores its register index. It needs 2 cycles after a class 4 producer and the plain distance after any other producer. Use code 0 on a move from hi/lo takes no reduced figure.
- R6: Register 0 never blocks a plain, base or store-data source. An instruction with neither destination enabled leaves the scoreboard unchanged.
- R7: When a register has been written by several issued producers, only the youngest one decides the stall.
- R8: `fpu_half` = 1 selects the larger figure for classes 6 and 7, and 0 selects the smaller one.
- R9: A stalled instruction records nothing. Its destination slots are written only in the cycle in which it actually issues.
- R10: `stall` is high only while `issue_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Synchronous clear of all pending slots |
| fpu_half | input | 1 | 1 = half-rate float latencies, 0 = full-rate |
| issue_valid | input | 1 | An instruction is presented this cycle |
| issue_cls | input | 3 | Producer class code of the presented instruction |
| dst_gpr_en | input | 1 | Presented instruction writes a general register |
| dst_reg | input | 5 | Index of that general register |
| dst_hilo_en | input | 1 | Presented instruction writes hi/lo |
| src_en | input | NUM_SRC (2) | Per-source valid |
| src_reg | input | NUM_SRC*5 (10) | Per-source register index, source i at bits [5i+4:5i] |
| src_use | input | NUM_SRC*2 (4) | Per-source use code, source i at bits [2i+1:2i] |
| stall | output | 1 | Hold the presented instruction this cycle |

## Verification
A producer issues on the rising edge that ends the cycle in which it was presented. The consumer is presented in the very next cycle, which is distance 1. Because `stall` is combinational, it is due in the same cycle as the inputs that cause it. The bench therefore drives on the falling edge, samples `stall` 1 ns later and, while it stays high, moves one cycle at a time. The cycle in which it first reads low is the measured distance, and that is compared with the figure from R2 to R8. The sweep covers every class, every use and both float modes.

// File: rtl/ilk_pkg.sv
// Package: shared types and latency constants of the operand interlock.
// Assumes one issue per cycle; distances are counted in issue cycles.
package ilk_pkg;

    typedef enum logic [2:0] {
        CLS_ARITH    = 3'd0,
        CLS_LOAD     = 3'd1,
        CLS_MUL_GPR  = 3'd2,
        CLS_HILO_RD  = 3'd3,
        CLS_HILO_WR  = 3'd4,
        CLS_MUL_ACC  = 3'd5,
        CLS_F2I      = 3'd6,
        CLS_COP_XFER = 3'd7
    } prod_cls_e;

    typedef enum logic [1:0] {
        USE_PLAIN  = 2'd0,
        USE_BASE   = 2'd1,
        USE_STDATA = 2'd2,
        USE_ACC    = 2'd3
    } src_use_e;

    localparam int LAT_ARITH      = 1;
    localparam int LAT_LOAD       = 2;
    localparam int LAT_MUL_GPR    = 5;
    localparam int LAT_HILO_RD    = 5;
    localparam int LAT_HILO_WR    = 1;
    localparam int LAT_MUL_ACC    = 1;
    localparam int LAT_F2I_HALF   = 10;
    localparam int LAT_F2I_FULL   = 5;
    localparam int LAT_XFER_HALF  = 4;
    localparam int LAT_XFER_FULL  = 2;
    localparam int LAT_WR_TO_ACC  = 2;
    localparam int BASE_EXTRA     = 1;

    // Largest distance any pair can require; slots retire at this age.
    localparam int LAT_MAX = LAT_F2I_HALF + BASE_EXTRA;
    // Counter must exceed LAT_MAX so that ages never alias while pending.
    localparam int AGE_W   = $clog2(LAT_MAX + 1);

    typedef logic [AGE_W-1:0] age_t;

endpackage

// File: rtl/ilk_lat_table.sv
// Module: required producer-to-consumer distance for one source.
// Pure combinational lookup on producer class, consumer use and float mode.
module ilk_lat_table
    import ilk_pkg::*;
(
    input  prod_cls_e cls,
    input  src_use_e  use_k,
    input  logic      fpu_half,
    output age_t      lat
);

    age_t plain;

    // Plain-use distance per producer class.
    always_comb begin
        case (cls)
            CLS_ARITH:    plain = age_t'(LAT_ARITH);
            CLS_LOAD:     plain = age_t'(LAT_LOAD);
            CLS_MUL_GPR:  plain = age_t'(LAT_MUL_GPR);
            CLS_HILO_RD:  plain = age_t'(LAT_HILO_RD);
            CLS_HILO_WR:  plain = age_t'(LAT_HILO_WR);
            CLS_MUL_ACC:  plain = age_t'(LAT_MUL_ACC);
            CLS_F2I:      plain = fpu_half ? age_t'(LAT_F2I_HALF) : age_t'(LAT_F2I_FULL);
            CLS_COP_XFER: plain = fpu_half ? age_t'(LAT_XFER_HALF) : age_t'(LAT_XFER_FULL);
            default:      plain = age_t'(LAT_ARITH);
        endcase
    end

    // Adjust for the way the consumer uses the operand.
    always_comb begin
        case (use_k)
            USE_BASE: lat = plain + age_t'(BASE_EXTRA);
            USE_ACC:  lat = (cls == CLS_HILO_WR) ? age_t'(LAT_WR_TO_ACC) : plain;
            default:  lat = plain;
        endcase
    end

endmodule

// File: rtl/ilk_scoreboard.sv
// Module: one slot per tracked register holding the youngest producer.
// Assumes at most one write per slot per cycle; a write overrides retirement,
// flush overrides a write. Slots retire once their age reaches LAT_MAX.
module ilk_scoreboard
    import ilk_pkg::*;
#(
    parameter int NENT = 33
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      wr_mask [NENT],
    input  prod_cls_e wr_cls,
    output logic      ent_vld [NENT],
    output prod_cls_e ent_cls [NENT],
    output age_t      ent_age [NENT]
);

    age_t now_q;

    // Free-running issue-cycle counter, wraps modulo 2**AGE_W.
    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + age_t'(1);
    end

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        logic      vld_q;
        prod_cls_e cls_q;
        age_t      stamp_q;
        age_t      age_w;

        assign age_w = now_q - stamp_q;

        // Slot update: clear, record a new producer, or retire an old one.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                vld_q   <= 1'b0;
                cls_q   <= CLS_ARITH;
                stamp_q <= '0;
            end else if (wr_mask[e]) begin
                vld_q   <= 1'b1;
                cls_q   <= wr_cls;
                stamp_q <= now_q;
            end else if (vld_q && age_w >= age_t'(LAT_MAX)) begin
                vld_q   <= 1'b0;
            end
        end

        assign ent_vld[e] = vld_q;
        assign ent_cls[e] = cls_q;
        assign ent_age[e] = age_w;
    end

endmodule

// File: rtl/ilk_src_check.sv
// Module: decides whether one source of the presented instruction is blocked.
// Accumulator sources look at the hi/lo slot; register 0 never blocks.
module ilk_src_check
    import ilk_pkg::*;
#(
    parameter int NENT  = 33,
    parameter int REG_W = 5
) (
    input  logic            en,
    input  logic [REG_W-1:0] reg_idx,
    input  src_use_e        use_k,
    input  logic            fpu_half,
    input  logic            ent_vld [NENT],
    input  prod_cls_e       ent_cls [NENT],
    input  age_t            ent_age [NENT],
    output logic            blocked
);

    localparam int IDX_W    = $clog2(NENT);
    localparam int HILO_IDX = NENT - 1;

    logic [IDX_W-1:0] idx;
    logic             live;
    age_t             need;

    // Select the slot this source depends on.
    always_comb begin
        idx  = (use_k == USE_ACC) ? IDX_W'(HILO_IDX) : IDX_W'(reg_idx);
        live = en && ((use_k == USE_ACC) || (reg_idx != '0));
    end

    ilk_lat_table u_lat (
        .cls      (ent_cls[idx]),
        .use_k    (use_k),
        .fpu_half (fpu_half),
        .lat      (need)
    );

    // Blocked while the producer is younger than the required distance.
    always_comb begin
        blocked = live && ent_vld[idx] && (ent_age[idx] < need);
    end

endmodule

// File: rtl/ilk_interlock.sv
// Module: issue-stage operand interlock (top).
// Assumes one instruction presented per cycle; it issues on the rising edge
// ending a cycle in which issue_valid is high, stall is low and flush is low.
module ilk_interlock
    import ilk_pkg::*;
#(
    parameter int NUM_REG = 32,
    parameter int NUM_SRC = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       fpu_half,
    input  logic                       issue_valid,
    input  logic [2:0]                 issue_cls,
    input  logic                       dst_gpr_en,
    input  logic [$clog2(NUM_REG)-1:0] dst_reg,
    input  logic                       dst_hilo_en,
    input  logic [NUM_SRC-1:0]         src_en,
    input  logic [NUM_SRC*$clog2(NUM_REG)-1:0] src_reg,
    input  logic [NUM_SRC*2-1:0]       src_use,
    output logic                       stall
);

    localparam int REG_W    = $clog2(NUM_REG);
    localparam int NENT     = NUM_REG + 1;
    localparam int HILO_IDX = NUM_REG;

    logic      ent_vld [NENT];
    prod_cls_e ent_cls [NENT];
    age_t      ent_age [NENT];
    logic      wr_mask [NENT];
    logic [NUM_SRC-1:0] blocked;
    logic      fire;

    assign fire  = issue_valid && !stall && !flush;
    assign stall = issue_valid && (|blocked);

    // Destination decode into per-slot write strobes.
    for (genvar e = 0; e < NENT; e++) begin : g_wr
        if (e == HILO_IDX) begin : g_hilo
            assign wr_mask[e] = fire && dst_hilo_en;
        end else if (e == 0) begin : g_zero
            assign wr_mask[e] = 1'b0;
        end else begin : g_gpr
            assign wr_mask[e] = fire && dst_gpr_en && (dst_reg == REG_W'(e));
        end
    end

    ilk_scoreboard #(.NENT(NENT)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_mask (wr_mask),
        .wr_cls  (prod_cls_e'(issue_cls)),
        .ent_vld (ent_vld),
        .ent_cls (ent_cls),
        .ent_age (ent_age)
    );

    // One dependency checker per source operand.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        ilk_src_check #(.NENT(NENT), .REG_W(REG_W)) u_chk (
            .en       (src_en[s]),
            .reg_idx  (src_reg[s*REG_W +: REG_W]),
            .use_k    (src_use_e'(src_use[s*2 +: 2])),
            .fpu_half (fpu_half),
            .ent_vld  (ent_vld),
            .ent_cls  (ent_cls),
            .ent_age  (ent_age),
            .blocked  (blocked[s])
        );
    end

endmodule

// File: rtl/ilk_interlock_chk.sv
// Module: property checker for the interlock, bound to every instance.
// Observes ports only; keeps its own count of consecutive stall cycles.
module ilk_interlock_chk
    import ilk_pkg::*;
#(
    parameter int NUM_SRC = 2,
    parameter int REG_W   = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     flush,
    input logic                     issue_valid,
    input logic [NUM_SRC-1:0]       src_en,
    input logic [NUM_SRC*REG_W-1:0] src_reg,
    input logic [NUM_SRC*2-1:0]     src_use,
    input logic                     stall
);

    logic [7:0] stall_run;
    logic       any_live;

    // Count consecutive cycles with stall high.
    always_ff @(posedge clk) begin
        if (!rst_n)               stall_run <= '0;
        else if (!stall)          stall_run <= '0;
        else if (stall_run != '1) stall_run <= stall_run + 8'd1;
    end

    // Whether any source can depend on the scoreboard at all.
    always_comb begin
        any_live = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (src_en[s] && (src_use[s*2 +: 2] == 2'd3 || src_reg[s*REG_W +: REG_W] != '0))
                any_live = 1'b1;
        end
    end

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !stall);

    a_r1_clear_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> !stall);

    a_r6_no_live_source: assert property (@(posedge clk) disable iff (!rst_n)
        !any_live |-> !stall);

    a_r10_stall_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> issue_valid);

    a_r2_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (stall_run < 8'(LAT_MAX)));

endmodule

bind ilk_interlock ilk_interlock_chk #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_ilk_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .issue_valid (issue_valid),
    .src_en      (src_en),
    .src_reg     (src_reg),
    .src_use     (src_use),
    .stall       (stall)
);

// File: tb/ilk_interlock_tb_top.sv
`timescale 1ns/1ps
module ilk_interlock_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       fpu_half = 1'b0;
    logic       issue_valid = 1'b0;
    logic [2:0] issue_cls = '0;
    logic       dst_gpr_en = 1'b0;
    logic [4:0] dst_reg = '0;
    logic       dst_hilo_en = 1'b0;
    logic [1:0] src_en = '0;
    logic [9:0] src_reg = '0;
    logic [3:0] src_use = '0;
    logic       stall;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ilk_interlock dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fpu_half(fpu_half),
        .issue_valid(issue_valid), .issue_cls(issue_cls),
        .dst_gpr_en(dst_gpr_en), .dst_reg(dst_reg), .dst_hilo_en(dst_hilo_en),
        .src_en(src_en), .src_reg(src_reg), .src_use(src_use), .stall(stall)
    );

    function automatic int plain_lat(int cls, bit half);
        case (cls)
            0: return 1;
            1: return 2;
            2: return 5;
            3: return 5;
            4: return 1;
            5: return 1;
            6: return half ? 10 : 5;
            default: return half ? 4 : 2;
        endcase
    endfunction

    function automatic int exp_lat(int cls, int use_k, bit half);
        if (use_k == 1) return plain_lat(cls, half) + 1;
        if (use_k == 3 && cls == 4) return 2;
        return plain_lat(cls, half);
    endfunction

    task automatic check(int got, int exp, string req);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic idle();
        issue_valid = 0; flush = 0; dst_gpr_en = 0; dst_hilo_en = 0;
        src_en = '0; src_reg = '0; src_use = '0; issue_cls = '0;
    endtask

    // Present an instruction at a falling edge (caller is at one).
    task automatic present(int cls, bit gen, int dreg, bit hen,
                           int slot, bit sen, int sreg, int suse);
        idle();
        issue_valid = 1; issue_cls = 3'(cls);
        dst_gpr_en = gen; dst_reg = 5'(dreg); dst_hilo_en = hen;
        src_reg = 10'h3FF;               // unused slot carries a non-zero index
        src_en[slot] = sen;
        src_reg[slot*5 +: 5] = 5'(sreg);
        src_use[slot*2 +: 2] = 2'(suse);
    endtask

    // Hold the presented instruction until it issues; returns the distance.
    task automatic wait_issue(output int k);
        k = 1;
        #1;
        while (stall && k < 40) begin
            @(negedge clk); #1; k++;
        end
        @(negedge clk);
    endtask

    task automatic producer(int cls, bit gen, int dreg, bit hen);
        int k;
        present(cls, gen, dreg, hen, 0, 0, 0, 0);
        wait_issue(k);
    endtask

    task automatic do_flush();
        idle(); flush = 1;
        @(negedge clk);
        flush = 0;
    endtask

    task automatic run_all();
        int k;
        string msg;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: after reset every read is free
        present(0, 0, 0, 1, 0, 1, 3, 1);
        wait_issue(k); check(k, 1, "R1 reset base read");
        present(0, 0, 0, 0, 1, 1, 0, 3);
        wait_issue(k); check(k, 1, "R1 reset acc read");

        // R2 R3 R4 R8: every class, every gpr use, both modes
        for (int h = 0; h < 2; h++) begin
            fpu_half = h[0];
            for (int c = 0; c < 8; c++) begin
                for (int u = 0; u < 3; u++) begin
                    int r = 1 + ((c * 3 + u) % 31);
                    int slot = (c + u) % 2;
                    do_flush();
                    producer(c, 1, r, 0);
                    present(0, 0, 0, 0, slot, 1, r, u);
                    wait_issue(k);
                    $sformat(msg, "%s cls=%0d use=%0d half=%0d",
                             (u == 1) ? "R3" : ((u == 2) ? "R4" : ((c >= 6) ? "R8" : "R2")), c, u, h);
                    check(k, exp_lat(c, u, h[0]), msg);
                end
            end
        end

        // R5: accumulator reads against every class writing hi/lo
        for (int h = 0; h < 2; h++) begin
            fpu_half = h[0];
            for (int c = 0; c < 8; c++) begin
                do_flush();
                producer(c, 0, 0, 1);
                present(0, 0, 0, 0, c % 2, 1, 17, 3);
                wait_issue(k);
                $sformat(msg, "R5 acc cls=%0d half=%0d", c, h);
                check(k, exp_lat(c, 3, h[0]), msg);
            end
        end
        fpu_half = 1;

        // R5: a plain read after a move-from-hi/lo keeps the full figure
        do_flush();
        producer(3, 1, 9, 0);
        present(0, 0, 0, 0, 0, 1, 9, 0);
        wait_issue(k); check(k, 5, "R5 hilo-read plain");

        // R6: register 0 and missing destinations
        do_flush();
        producer(1, 1, 0, 0);
        present(0, 0, 0, 0, 0, 1, 0, 1);
        wait_issue(k); check(k, 1, "R6 reg0 base");
        do_flush();
        producer(6, 0, 6, 0);
        present(0, 0, 0, 0, 1, 1, 6, 1);
        wait_issue(k); check(k, 1, "R6 no gpr dest");
        do_flush();
        producer(4, 0, 0, 0);
        present(0, 0, 0, 0, 0, 1, 0, 3);
        wait_issue(k); check(k, 1, "R6 no hilo dest");

        // R7: youngest producer governs
        do_flush();
        producer(2, 1, 9, 0);
        producer(0, 1, 9, 0);
        present(0, 0, 0, 0, 0, 1, 9, 0);
        wait_issue(k); check(k, 1, "R7 arith after mul");
        do_flush();
        producer(0, 1, 9, 0);
        producer(2, 1, 9, 0);
        present(0, 0, 0, 0, 0, 1, 9, 0);
        wait_issue(k); check(k, 5, "R7 mul after arith");

        // R9: stalled instruction records its destination only on issue
        do_flush();
        producer(1, 1, 5, 0);
        present(2, 1, 7, 0, 0, 1, 5, 1);
        wait_issue(k); check(k, 3, "R9 stalled base wait");
        present(0, 0, 0, 0, 1, 1, 7, 0);
        wait_issue(k); check(k, 5, "R9 stamp at issue");

        // R10: no stall without a presented instruction
        do_flush();
        producer(6, 1, 11, 0);
        idle(); src_en = 2'b01; src_reg = 10'd11; src_use = 4'd1;
        #1; check(int'(stall), 0, "R10 idle no stall");
        @(negedge clk);

        // R1: flush clears pending producers
        do_flush();
        producer(6, 1, 12, 0);
        do_flush();
        present(0, 0, 0, 0, 0, 1, 12, 1);
        wait_issue(k); check(k, 1, "R1 flush clears");

        // R1: instruction presented during flush is not recorded
        idle(); issue_valid = 1; issue_cls = 3'd6; dst_gpr_en = 1; dst_reg = 5'd14; flush = 1;
        @(negedge clk);
        present(0, 0, 0, 0, 0, 1, 14, 1);
        wait_issue(k); check(k, 1, "R1 flush blocks insert");

        // R2: a slot retires and does not alias when the counter wraps
        do_flush();
        producer(6, 1, 13, 0);
        idle();
        repeat (15) @(negedge clk);
        present(0, 0, 0, 0, 0, 1, 13, 1);
        wait_issue(k); check(k, 1, "R2 retired after wrap");
        idle();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL R0 watchdog actual=timeout expected=completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule